// File: doc/BRIEF.md
# Serial Command Stream Decoder

This block sits at the front of a detector front-end controller. It takes a one-bit control stream, one bit on each clock, and cuts it into 8-bit words, most significant bit first. The block first hunts for an idle word at any bit offset. Once it has framed the stream, it interprets each aligned word. A recognised command becomes a single-cycle strobe on a dedicated output line. The strobes cover the trigger accept and reject lines, the reset pulses, the test pulse and the standard-mode on/off controls.

One word family tunnels JTAG traffic. Each such word carries one TMS bit and one TDI bit, and each bit is followed by its complement. A valid word updates the registered TMS and TDI lines and fires one TCK pulse. A word whose complement check fails raises a sticky error instead.

Aligned words that match no code raise a sticky unknown flag. Two unknown words in a row abandon the framing. A dedicated receiver-reset word clears the block's own flags and framing, and drives none of the outputs.

Top module: `ser_cmd_decoder`

## Requirements
- R1: After reset every strobe, `jt_tck`, `jt_tms`, `jt_tdi`, `frame_locked`, `unknown_err` and `jtag_err` are 0.
- R2: `frame_locked` rises only when a second idle word 11001100 ends exactly 8 bits after an earlier one. The first idle may sit at any bit offset. A single idle, or an idle followed by a non-idle word, leaves the block unlocked.
- R3: Bits arrive MSB first. A word is decoded only while locked and only on the 8-bit boundaries that follow the lock. Its strobe is high in the clock cycle right after the edge that captures the word's 8th bit. While unlocked, no word produces a strobe.
- R4: The code map is as follows.
  - Trigger strobes: 01010110 → `trig_l1`, 01011010 → `trig_l2_acc`, 01010101 → `trig_l2_rej`.
  - Reset strobes: 11101000 → `rst_chip`, 11100100 → `rst_link`, 11100010 → `rst_pix`, 11100001 → `trst_pix`.
  - Other strobes: 11011000 → `test_pulse`, 10110100 → `std_mode_on`, 10110010 → `std_mode_off`.
- R5: Each decoded command pulses exactly one output, for exactly one cycle, and no other strobe or `jt_tck` is high in that cycle.
- R6: A word whose top nibble is 1010 is a JTAG word. Its bit 3 carries TMS and bit 2 carries ~TMS; bit 1 carries TDI and bit 0 carries ~TDI. When both pairs are complementary, `jt_tms`/`jt_tdi` take the bit values and `jt_tck` pulses for one cycle. The two lines then hold their values until the next valid JTAG word.
- R7: A JTAG word that fails either complement check produces no `jt_tck` pulse. It leaves `jt_tms`/`jt_tdi` unchanged and sets `jtag_err`, which stays set until a receiver reset.
- R8: An aligned word that matches no code sets the sticky `unknown_err`. A second unknown word immediately after the first clears `frame_locked` and restarts the idle search. Any recognised word in between resets the run.
- R9: The word 00000000, decoded while locked, clears `frame_locked`, `unknown_err` and `jtag_err` and pulses no output.
- R10: An idle word decoded while locked pulses no output and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_in | input | 1 | Serial control stream, MSB of each word first |
| trig_l1 | output | 1 | Level-1 trigger strobe |
| trig_l2_acc | output | 1 | Level-2 accept strobe |
| trig_l2_rej | output | 1 | Level-2 reject strobe |
| rst_chip | output | 1 | Whole-chip reset strobe |
| rst_link | output | 1 | Serial link chip reset strobe |
| rst_pix | output | 1 | Pixel chip reset strobe |
| trst_pix | output | 1 | Pixel JTAG TRST strobe |
| test_pulse | output | 1 | Test pulse strobe |
| std_mode_on | output | 1 | Standard mode on strobe |
| std_mode_off | output | 1 | Standard mode off strobe |
| jt_tck | output | 1 | Tunnelled JTAG clock pulse |
| jt_tms | output | 1 | Registered tunnelled TMS |
| jt_tdi | output | 1 | Registered tunnelled TDI |
| frame_locked | output | 1 | Word framing established |
| unknown_err | output | 1 | Sticky unknown-command flag |
| jtag_err | output | 1 | Sticky JTAG complement error flag |

## Verification
Two events can fall on the same decode edge. When a second unknown word arrives, the unknown flag is raised and the framing is dropped at the same edge. The bench provokes this by sending two unrecognised words back to back and then a valid trigger code. It judges the outcome in three ways:
- Right after the second word, `frame_locked` is low and `unknown_err` is high.
- The trigger code that follows produces no strobe.
- An idle word placed between two unknown words keeps the lock.

// File: rtl/ser_cmd_decoder.sv
module ser_cmd_decoder #(
  parameter int WORD_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  output logic trig_l1,
  output logic trig_l2_acc,
  output logic trig_l2_rej,
  output logic rst_chip,
  output logic rst_link,
  output logic rst_pix,
  output logic trst_pix,
  output logic test_pulse,
  output logic std_mode_on,
  output logic std_mode_off,
  output logic jt_tck,
  output logic jt_tms,
  output logic jt_tdi,
  output logic frame_locked,
  output logic unknown_err,
  output logic jtag_err
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [7:0] C_IDLE  = 8'b1100_1100;
  localparam logic [7:0] C_RXRST = 8'b0000_0000;
  localparam logic [7:0] C_L1    = 8'b0101_0110;
  localparam logic [7:0] C_L2A   = 8'b0101_1010;
  localparam logic [7:0] C_L2R   = 8'b0101_0101;
  localparam logic [7:0] C_RCHIP = 8'b1110_1000;
  localparam logic [7:0] C_RLINK = 8'b1110_0100;
  localparam logic [7:0] C_RPIX  = 8'b1110_0010;
  localparam logic [7:0] C_TRST  = 8'b1110_0001;
  localparam logic [7:0] C_TP    = 8'b1101_1000;
  localparam logic [7:0] C_SON   = 8'b1011_0100;
  localparam logic [7:0] C_SOFF  = 8'b1011_0010;

  logic [WORD_W-2:0] hist;
  logic [CNT_W-1:0]  bitcnt;
  logic              armed;
  logic              unk_prev;
  logic [9:0]        pulse_q;
  logic [9:0]        hit;
  logic              known;

  wire [7:0] word     = {hist, ser_in};
  wire       is_idle  = (word == C_IDLE);
  wire       at_edge  = (bitcnt == LAST);
  wire       boundary = frame_locked && at_edge;
  wire       jt_word  = (word[7:4] == 4'b1010);
  wire       jt_ok    = jt_word && (word[3] ^ word[2]) && (word[1] ^ word[0]);
  wire       rx_clear = boundary && (word == C_RXRST);

  always_comb begin
    hit   = '0;
    known = 1'b1;
    case (word)
      C_L1:    hit[9] = 1'b1;
      C_L2A:   hit[8] = 1'b1;
      C_L2R:   hit[7] = 1'b1;
      C_RCHIP: hit[6] = 1'b1;
      C_RLINK: hit[5] = 1'b1;
      C_RPIX:  hit[4] = 1'b1;
      C_TRST:  hit[3] = 1'b1;
      C_TP:    hit[2] = 1'b1;
      C_SON:   hit[1] = 1'b1;
      C_SOFF:  hit[0] = 1'b1;
      C_IDLE, C_RXRST: known = 1'b1;
      default: known = jt_word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist         <= '0;
      bitcnt       <= '0;
      armed        <= 1'b0;
      frame_locked <= 1'b0;
      unk_prev     <= 1'b0;
      unknown_err  <= 1'b0;
      jtag_err     <= 1'b0;
      pulse_q      <= '0;
      jt_tck       <= 1'b0;
      jt_tms       <= 1'b0;
      jt_tdi       <= 1'b0;
    end else begin
      hist    <= word[WORD_W-2:0];
      bitcnt  <= (!frame_locked && !armed && is_idle) ? '0 : bitcnt + 1'b1;
      pulse_q <= boundary ? hit : '0;
      jt_tck  <= boundary && jt_ok;
      if (boundary && jt_ok) begin
        jt_tms <= word[3];
        jt_tdi <= word[1];
      end
      if (!frame_locked) begin
        if (!armed) begin
          if (is_idle) armed <= 1'b1;
        end else if (at_edge) begin
          if (is_idle) frame_locked <= 1'b1;
          else         armed        <= 1'b0;
        end
      end else if (at_edge) begin
        if (rx_clear) begin
          frame_locked <= 1'b0;
          armed        <= 1'b0;
          unk_prev     <= 1'b0;
          unknown_err  <= 1'b0;
          jtag_err     <= 1'b0;
        end else if (!known) begin
          unknown_err <= 1'b1;
          unk_prev    <= 1'b1;
          if (unk_prev) begin
            frame_locked <= 1'b0;
            armed        <= 1'b0;
            unk_prev     <= 1'b0;
          end
        end else begin
          unk_prev <= 1'b0;
          if (jt_word && !jt_ok) jtag_err <= 1'b1;
        end
      end
    end
  end

  assign {trig_l1, trig_l2_acc, trig_l2_rej, rst_chip, rst_link, rst_pix,
          trst_pix, test_pulse, std_mode_on, std_mode_off} = pulse_q;

  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pulse_q, jt_tck}));
  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (|{pulse_q, jt_tck}) |=> !(|{pulse_q, jt_tck}));
  a_r3_only_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (|{pulse_q, jt_tck}) |-> $past(frame_locked));
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(jtag_err) && !$past(rx_clear)) |-> jtag_err);
  a_r6_jtag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !jt_tck |-> ($stable(jt_tms) && $stable(jt_tdi)));
  a_r2_lock_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_locked) |-> $past(is_idle));
endmodule

// File: tb/sim_ser_cmd_decoder.sv
`timescale 1ns/1ps
module sim_ser_cmd_decoder;
  logic clk = 0, rst_n = 0, sin = 0;
  logic l1, l2a, l2r, rchip, rlink, rpix, trst, tp, son, soff, tck, tms, tdi, lck, unk, jerr;
  int nchk = 0, nerr = 0;
  int pc [11];
  logic [10:0] s_str;
  logic s_lck, s_unk, s_jerr, s_tms, s_tdi;

  localparam int TCK = 10, L1 = 9, L2A = 8, L2R = 7, RCHIP = 6, RLINK = 5,
                 RPIX = 4, TRST = 3, TP = 2, SON = 1, SOFF = 0, NONE = -1;

  always #10 clk = ~clk;

  ser_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(sin),
    .trig_l1(l1), .trig_l2_acc(l2a), .trig_l2_rej(l2r),
    .rst_chip(rchip), .rst_link(rlink), .rst_pix(rpix), .trst_pix(trst),
    .test_pulse(tp), .std_mode_on(son), .std_mode_off(soff),
    .jt_tck(tck), .jt_tms(tms), .jt_tdi(tdi),
    .frame_locked(lck), .unknown_err(unk), .jtag_err(jerr));

  wire [10:0] strb = {tck, l1, l2a, l2r, rchip, rlink, rpix, trst, tp, son, soff};

  always @(posedge clk) begin
    #2;
    if (rst_n) for (int k = 0; k < 11; k++) pc[k] += int'(strb[k]);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      sin = b[i];
    end
    @(posedge clk);
    #3;
    s_str = strb; s_lck = lck; s_unk = unk; s_jerr = jerr; s_tms = tms; s_tdi = tdi;
  endtask

  task automatic cmd(input logic [7:0] b, input int idx, input string tag);
    int base [11];
    base = pc;
    send(b);
    for (int k = 0; k < 11; k++)
      chk($sformatf("%s line %0d", tag, k), pc[k] - base[k], (k == idx) ? 1 : 0);
  endtask

  task automatic lock_up(input string tag);
    send(8'hCC);
    send(8'hCC);
    chk({tag, " R2 locked after two idles"}, s_lck, 1);
  endtask

  task automatic t_reset();
    chk("R1 strobes", strb, 0);
    chk("R1 lock/flags", {lck, unk, jerr, tms, tdi}, 0);
  endtask

  task automatic t_unlocked();
    cmd(8'h56, NONE, "R3 L1 while unlocked");
    chk("R3 still unlocked", lck, 0);
  endtask

  task automatic t_lock();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      sin = i[0] ? 1'b0 : 1'b1;
    end
    send(8'hCC);
    chk("R2 single idle no lock", s_lck, 0);
    send(8'hA5);
    send(8'hCC);
    chk("R2 idle, other, idle no lock", s_lck, 0);
    send(8'hCC);
    chk("R2 lock at odd offset", s_lck, 1);
  endtask

  task automatic t_commands();
    cmd(8'b0101_0110, L1,    "R4 R3 L1");
    chk("R5 L1 only line in cycle", s_str, 11'b1 << L1);
    cmd(8'b0101_1010, L2A,   "R4 L2 accept");
    cmd(8'b0101_0101, L2R,   "R4 L2 reject");
    cmd(8'b1110_1000, RCHIP, "R4 chip reset");
    cmd(8'b1110_0100, RLINK, "R4 link reset");
    cmd(8'b1110_0010, RPIX,  "R4 pixel reset");
    cmd(8'b1110_0001, TRST,  "R4 pixel trst");
    cmd(8'b1101_1000, TP,    "R4 R5 test pulse");
    chk("R5 test pulse alone", s_str, 11'b1 << TP);
    cmd(8'b1011_0100, SON,   "R4 std on");
    cmd(8'b1011_0010, SOFF,  "R4 std off");
    cmd(8'hCC, NONE, "R10 idle while locked");
    chk("R10 flags after idle", {s_lck, s_unk, s_jerr}, 3'b100);
  endtask

  task automatic t_jtag();
    cmd(8'b1010_1001, TCK, "R6 jtag tms1 tdi0");
    chk("R6 tms/tdi 1/0", {s_tms, s_tdi}, 2'b10);
    cmd(8'b1010_0110, TCK, "R6 jtag tms0 tdi1");
    chk("R6 tms/tdi 0/1", {s_tms, s_tdi}, 2'b01);
    cmd(8'b1010_1101, NONE, "R7 bad tms complement");
    chk("R7 jtag_err set", s_jerr, 1);
    chk("R7 tms/tdi held", {s_tms, s_tdi}, 2'b01);
    cmd(8'b1010_1000, NONE, "R7 bad tdi complement");
    chk("R7 jtag_err stays", s_jerr, 1);
    cmd(8'b0101_0110, L1, "R7 decode continues");
    chk("R7 still sticky", s_jerr, 1);
  endtask

  task automatic t_rxreset();
    cmd(8'h00, NONE, "R9 receiver reset");
    chk("R9 flags and lock cleared", {s_lck, s_unk, s_jerr}, 0);
    cmd(8'b0101_0110, NONE, "R9 unlocked after clear");
    lock_up("R9 relock");
  endtask

  task automatic t_unknown();
    cmd(8'h3F, NONE, "R8 unknown word");
    chk("R8 unk set, lock kept", {s_unk, s_lck}, 2'b11);
    send(8'hCC);
    cmd(8'h3F, NONE, "R8 unknown after idle");
    chk("R8 idle breaks run", s_lck, 1);
    cmd(8'h3F, NONE, "R8 second consecutive unknown");
    chk("R8 lock dropped with flag", {s_unk, s_lck}, 2'b10);
    cmd(8'b0101_0110, NONE, "R8 no decode after drop");
    lock_up("R8 relock");
    chk("R8 unk sticky across relock", s_unk, 1);
  endtask

  initial begin
    #(20 * 100000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_unlocked();
    t_lock();
    t_commands();
    t_jtag();
    t_rxreset();
    t_unknown();
    t_rxreset();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule